// File: doc/BRIEF.md
# Byte-Lane Video Output Formatter

The formatter sits at the end of a pixel pipeline and places a three-component pixel onto a wide parallel output bus. The components are luma/green, blue-difference/blue and red-difference/red. The output bus has one byte lane per component width. Each lane has its own programmable source:

- the current value of any component;
- that component as it was one pixel clock earlier;
- a constant zero;
- a hold code that freezes the lane at its last value.

A data-enable strobe travels alongside the pixel with the same latency as the data.

Software sets the formatter up through a small write-only register port. One configuration word holds a per-lane enable, a global enable and a modulo count. Three lane-select words each carry a 3-bit source code.

The modulo count thins out lane updates during active video. A count of N lets the lanes take a new value on only one pixel in every N+1 within a data-enabled run. A count of zero updates the lanes on every pixel, which is the setting for plain 24-bit RGB with data enable. For that setting the low lane carries red, the middle lane green and the high lane blue.

Top module: `vid_lane_fmt`

## Requirements
- R1: After reset `out_data` and `out_de` are zero, and every register is zero, so the formatter starts switched off.
- R2: Register writes take effect on the clock edge where `reg_we` is high, and the new value governs the pixel on the next edge. The offsets are fixed:
  - 0x4 is the configuration word: bit 0, bit 1 and bit 2 enable the low, middle and high lane; bit 6 is the global enable; bits starting at bit 8 hold the modulo count.
  - 0x8, 0xC and 0x10 are the low, middle and high lane selects, each taking its 3-bit source code from data bits [2:0].
- R3: A write to any other offset (for example 0x0 or 0x14) changes nothing.
- R4: The source codes that pass a current component are 1 (luma/green), 3 (blue), 5 (red) and 0 (constant zero). The low lane is `out_data[7:0]`, the middle lane `out_data[15:8]` and the high lane `out_data[23:16]`.
- R5: Codes 2, 4 and 6 pass luma/green, blue and red as sampled one pixel clock before the current one.
- R6: Code 7 keeps the lane at the value it last drove, whatever the input pixel does.
- R7: A lane whose own enable is clear, or whose global enable is clear, drives zero on the next pixel. A lane in hold that is re-enabled holds that zero.
- R8: Each lane is registered with one pixel clock of latency. `out_de` is `in_de` delayed by exactly one clock.
- R9: With modulo count N, an enabled lane loads a new value only when the internal phase is zero. The phase is reset to zero by any pixel with `in_de` low, and within a run of `in_de` high it steps 0, 1, ... N and wraps. Between loads an enabled lane keeps its value.
- R10: Writing zero to the configuration word turns the formatter off: all lanes drive zero from the next pixel on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register byte offset |
| reg_wdata | input | DATA_W (32) | Register write data |
| in_yg | input | COMP_W (8) | Luma/green component |
| in_cb | input | COMP_W (8) | Blue-difference/blue component |
| in_cr | input | COMP_W (8) | Red-difference/red component |
| in_de | input | 1 | Input data enable |
| out_data | output | 3*COMP_W (24) | Formatted output bus, low lane in the least significant byte |
| out_de | output | 1 | Data enable delayed to match `out_data` |

## Verification
A register write and a pixel load can land on the same clock edge. The bench provokes this in two ways:
- it writes a hold code to a lane while presenting a new pixel;
- it clears and later restores that lane's enable while pixels keep flowing.

It then judges that the pixel on the write edge is still formatted under the old setting and that the new setting governs only the following pixel. The modulo phase and the hold code can also both freeze a lane in one cycle. The bench separates them by driving data-enabled runs at modulo counts one and two and comparing each output byte with the phase it expects pixel by pixel.

// File: rtl/vid_lane_fmt_pkg.sv
package vid_lane_fmt_pkg;

   // Lane source codes; numeric values are part of the register interface.
   typedef enum logic [2:0] {
      SRC_ZERO = 3'd0,
      SRC_YG   = 3'd1,
      SRC_YG_D = 3'd2,
      SRC_CB   = 3'd3,
      SRC_CB_D = 3'd4,
      SRC_CR   = 3'd5,
      SRC_CR_D = 3'd6,
      SRC_HOLD = 3'd7
   } src_e;

   localparam int NUM_LANES = 3;   // also the number of components
   localparam int COMP_YG   = 0;
   localparam int COMP_CB   = 1;
   localparam int COMP_CR   = 2;

   // Register offsets (byte addresses)
   localparam int OFF_CFG      = 'h4;
   localparam int OFF_SEL_BASE = 'h8;
   localparam int OFF_SEL_STEP = 4;

   // Configuration word bit positions
   localparam int CFG_LANE_EN_LSB = 0;
   localparam int CFG_GLOBAL_EN   = 6;
   localparam int CFG_MOD_LSB     = 8;
   localparam int SEL_W           = 3;

endpackage

// File: rtl/vid_fmt_regs.sv
module vid_fmt_regs
   import vid_lane_fmt_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int MOD_W  = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [DATA_W-1:0]                  wdata,
   output logic [NUM_LANES-1:0][SEL_W-1:0]    sel_q,
   output logic [NUM_LANES-1:0]               lane_en_q,
   output logic                               glob_en_q,
   output logic [MOD_W-1:0]                   mod_q
);

   localparam int MOD_MSB = CFG_MOD_LSB + MOD_W - 1;
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("vid_fmt_regs: ADDR_W must reach offset 0x10");
   end
   if (DATA_W <= MOD_MSB + 1) begin : g_bad_data
      $error("vid_fmt_regs: DATA_W too narrow for the modulo field");
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[DATA_W-1:MOD_MSB+1], wdata[CFG_GLOBAL_EN+1],
                           wdata[CFG_GLOBAL_EN-1:NUM_LANES]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= '0;
         lane_en_q <= '0;
         glob_en_q <= 1'b0;
         mod_q     <= '0;
      end else if (we) begin
         if (addr == A_CFG) begin
            lane_en_q <= wdata[CFG_LANE_EN_LSB +: NUM_LANES];
            glob_en_q <= wdata[CFG_GLOBAL_EN];
            mod_q     <= wdata[CFG_MOD_LSB +: MOD_W];
         end
         for (int l = 0; l < NUM_LANES; l++) begin
            if (addr == ADDR_W'(OFF_SEL_BASE + OFF_SEL_STEP * l))
               sel_q[l] <= wdata[SEL_W-1:0];
         end
      end
   end

endmodule

// File: rtl/vid_fmt_phase.sv
module vid_fmt_phase #(
   parameter int MOD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             de,
   input  logic [MOD_W-1:0] mod_cnt,
   output logic             load
);

   if (MOD_W < 1) begin : g_bad_mod
      $error("vid_fmt_phase: MOD_W must be at least 1");
   end

   logic [MOD_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                phase_q <= '0;
      else if (!de)              phase_q <= '0;
      else if (phase_q >= mod_cnt) phase_q <= '0;
      else                       phase_q <= phase_q + 1'b1;
   end

   assign load = (phase_q == '0);

   // R9: a blanked pixel always leaves the phase ready to load
   assert_blank_rephase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !de |=> load);

   // R9: with a nonzero count, a load inside a data-enabled run is not repeated next pixel
   assert_skip_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (de && load && mod_cnt != '0) |=> !load);

endmodule

// File: rtl/vid_fmt_lane.sv
module vid_fmt_lane
   import vid_lane_fmt_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  src_e                              sel,
   input  logic                              lane_on,
   input  logic                              load,
   input  logic [NUM_LANES-1:0][COMP_W-1:0]  comp_cur,
   input  logic [NUM_LANES-1:0][COMP_W-1:0]  comp_dly,
   output logic [COMP_W-1:0]                 q
);

   logic [COMP_W-1:0] pick;

   always_comb begin
      unique case (sel)
         SRC_ZERO: pick = '0;
         SRC_YG:   pick = comp_cur[COMP_YG];
         SRC_YG_D: pick = comp_dly[COMP_YG];
         SRC_CB:   pick = comp_cur[COMP_CB];
         SRC_CB_D: pick = comp_dly[COMP_CB];
         SRC_CR:   pick = comp_cur[COMP_CR];
         SRC_CR_D: pick = comp_dly[COMP_CR];
         SRC_HOLD: pick = q;
         default:  pick = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (!lane_on) q <= '0;
      else if (load)    q <= pick;
   end

   // R7: a disabled lane shows zero one pixel later
   assert_off_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_on |=> q == '0);

   // R6: hold code freezes an enabled lane
   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_on && sel == SRC_HOLD) |=> $stable(q));

   // R9: an enabled lane outside its load phase keeps its value
   assert_phase_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_on && !load) |=> $stable(q));

endmodule

// File: rtl/vid_lane_fmt.sv
module vid_lane_fmt
   import vid_lane_fmt_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int MOD_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_we,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   input  logic [COMP_W-1:0]             in_yg,
   input  logic [COMP_W-1:0]             in_cb,
   input  logic [COMP_W-1:0]             in_cr,
   input  logic                          in_de,
   output logic [NUM_LANES*COMP_W-1:0]   out_data,
   output logic                          out_de
);

   if (COMP_W < 1) begin : g_bad_comp
      $error("vid_lane_fmt: COMP_W must be at least 1");
   end

   logic [NUM_LANES-1:0][SEL_W-1:0]   sel_q;
   logic [NUM_LANES-1:0]              lane_en_q;
   logic                              glob_en_q;
   logic [MOD_W-1:0]                  mod_q;
   logic                              load;
   logic [NUM_LANES-1:0][COMP_W-1:0]  comp_cur;
   logic [NUM_LANES-1:0][COMP_W-1:0]  comp_dly;

   assign comp_cur[COMP_YG] = in_yg;
   assign comp_cur[COMP_CB] = in_cb;
   assign comp_cur[COMP_CR] = in_cr;

   vid_fmt_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MOD_W  (MOD_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .sel_q     (sel_q),
      .lane_en_q (lane_en_q),
      .glob_en_q (glob_en_q),
      .mod_q     (mod_q)
   );

   vid_fmt_phase #(
      .MOD_W (MOD_W)
   ) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .de      (in_de),
      .mod_cnt (mod_q),
      .load    (load)
   );

   // One-pixel delay copy of each component
   for (genvar c = 0; c < NUM_LANES; c++) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) comp_dly[c] <= '0;
         else        comp_dly[c] <= comp_cur[c];
      end
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      vid_fmt_lane #(
         .COMP_W (COMP_W)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (src_e'(sel_q[l])),
         .lane_on  (glob_en_q & lane_en_q[l]),
         .load     (load),
         .comp_cur (comp_cur),
         .comp_dly (comp_dly),
         .q        (out_data[l*COMP_W +: COMP_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_de <= 1'b0;
      else        out_de <= in_de;
   end

   // R8: strobe follows input by exactly one clock
   assert_de_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_de |=> out_de);
   assert_de_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_de |=> !out_de);

   // R10: global enable clear blanks the whole bus on the next pixel
   assert_global_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en_q |=> out_data == '0);

endmodule

// File: tb/vid_lane_fmt_bench.sv
module vid_lane_fmt_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [7:0]  in_yg = '0, in_cb = '0, in_cr = '0;
   logic        in_de = 1'b0;
   logic [23:0] out_data;
   logic        out_de;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vid_lane_fmt u_vid_lane_fmt (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .in_yg(in_yg), .in_cb(in_cb), .in_cr(in_cr),
      .in_de(in_de), .out_data(out_data), .out_de(out_de)
   );

   // {lo_sel, mid_sel, hi_sel, cfg[15:0], expected bus} after pixel A then pixel B
   // A = {yg 11, cb 22, cr 33}, B = {yg 44, cb 55, cr 66}
   localparam logic [48:0] VEC [7] = '{
      {3'd5, 3'd1, 3'd3, 16'h0047, 24'h554466},   // R4 plain RGB lane order
      {3'd6, 3'd2, 3'd4, 16'h0047, 24'h221133},   // R5 delayed sources
      {3'd0, 3'd1, 3'd1, 16'h0047, 24'h444400},   // R4 zero code, shared source
      {3'd5, 3'd1, 3'd3, 16'h0045, 24'h550066},   // R7 middle lane disabled
      {3'd5, 3'd1, 3'd3, 16'h0007, 24'h000000},   // R7 global enable clear
      {3'd1, 3'd3, 3'd5, 16'h0043, 24'h005544},   // R7 high lane disabled, R2 map
      {3'd2, 3'd4, 3'd6, 16'h0047, 24'h332211}    // R5 delayed, permuted
   };

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_we = 1'b0;
   endtask

   task automatic pix(input logic [7:0] y, input logic [7:0] b, input logic [7:0] r,
                      input logic de);
      in_yg = y; in_cb = b; in_cr = r; in_de = de;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 bus after reset", {8'h0, out_data}, 32'h0);
      chk("R1 de after reset", {31'h0, out_de}, 32'h0);
      pix(8'h44, 8'h55, 8'h66, 1'b1);
      cyc();
      chk("R1 formatter off from reset", {8'h0, out_data}, 32'h0);
      chk("R8 de delayed", {31'h0, out_de}, 32'h1);

      // Table walk
      for (int i = 0; i < 7; i++) begin
         wr(5'h08, {29'h0, VEC[i][48:46]});
         wr(5'h0C, {29'h0, VEC[i][45:43]});
         wr(5'h10, {29'h0, VEC[i][42:40]});
         wr(5'h04, {16'h0, VEC[i][39:24]});
         pix(8'h11, 8'h22, 8'h33, 1'b1);
         cyc();
         pix(8'h44, 8'h55, 8'h66, 1'b1);
         cyc();
         chk($sformatf("R4/R5/R7 vector %0d", i), {8'h0, out_data}, {8'h0, VEC[i][23:0]});
         chk("R8 de with data", {31'h0, out_de}, 32'h1);
      end

      // R3: unmapped offsets ignored
      wr(5'h08, 32'h5); wr(5'h0C, 32'h1); wr(5'h10, 32'h3); wr(5'h04, 32'h47);
      wr(5'h00, 32'h0);
      wr(5'h14, 32'h0);
      wr(5'h18, 32'hFFFF_FFFF);
      cyc();
      chk("R3 unmapped writes ignored", {8'h0, out_data}, 32'h554466);

      // R6 hold, written on the same edge as a new pixel
      pix(8'h77, 8'h88, 8'h99, 1'b1);
      wr(5'h08, 32'h7);
      chk("R2 old select governs write edge", {8'h0, out_data}, 32'h887799);
      cyc();
      chk("R6 hold keeps low lane", {8'h0, out_data}, 32'h887799);
      pix(8'h12, 8'h34, 8'h56, 1'b1);
      cyc();
      chk("R6 hold ignores new pixel", {8'h0, out_data}, 32'h341299);
      wr(5'h04, 32'h46);
      chk("R2 old enable governs write edge", {8'h0, out_data}, 32'h341299);
      cyc();
      chk("R7 lane disabled drives zero", {8'h0, out_data}, 32'h341200);
      wr(5'h04, 32'h47);
      cyc();
      chk("R7 re-enabled hold keeps zero", {8'h0, out_data}, 32'h341200);

      // R10: zero config turns formatter off
      wr(5'h04, 32'h0);
      cyc();
      chk("R10 zero config blanks bus", {8'h0, out_data}, 32'h0);

      // R9 modulo count 1
      wr(5'h08, 32'h5); wr(5'h0C, 32'h0); wr(5'h10, 32'h0);
      wr(5'h04, 32'h0147);
      pix(8'h0, 8'h0, 8'h00, 1'b0);
      cyc();
      pix(8'h0, 8'h0, 8'h01, 1'b1); cyc();
      chk("R9 mod1 pixel 1 loads", {8'h0, out_data}, 32'h01);
      pix(8'h0, 8'h0, 8'h02, 1'b1); cyc();
      chk("R9 mod1 pixel 2 skipped", {8'h0, out_data}, 32'h01);
      pix(8'h0, 8'h0, 8'h03, 1'b1); cyc();
      chk("R9 mod1 pixel 3 loads", {8'h0, out_data}, 32'h03);
      pix(8'h0, 8'h0, 8'h04, 1'b1); cyc();
      chk("R9 mod1 pixel 4 skipped", {8'h0, out_data}, 32'h03);
      pix(8'h0, 8'h0, 8'h05, 1'b0); cyc();
      chk("R9 blank pixel loads", {8'h0, out_data}, 32'h05);
      chk("R8 de low follows", {31'h0, out_de}, 32'h0);

      // R9 modulo count 2, starting mid-phase after a blank
      wr(5'h04, 32'h0247);
      pix(8'h0, 8'h0, 8'h10, 1'b1); cyc();
      chk("R9 mod2 first loads", {8'h0, out_data}, 32'h10);
      pix(8'h0, 8'h0, 8'h11, 1'b1); cyc();
      chk("R9 mod2 second skipped", {8'h0, out_data}, 32'h10);
      pix(8'h0, 8'h0, 8'h12, 1'b1); cyc();
      chk("R9 mod2 third skipped", {8'h0, out_data}, 32'h10);
      pix(8'h0, 8'h0, 8'h13, 1'b1); cyc();
      chk("R9 mod2 fourth loads", {8'h0, out_data}, 32'h13);

      finish_run();
   end

endmodule